// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block is a real-time calendar that holds seconds, minutes, hours, day of month, month and a two-digit year (2000 to 2099), each as one packed-BCD byte. A single-cycle tick enable running at the sub-second rate (32768 per second by default) drives a sub-second counter. Each time that counter completes a second, the calendar moves forward by one second and carries through every field, with month lengths and leap Februaries taken into account.

Software reaches the block through a byte-wide register bus that runs in the tick's clock domain. Through it, software sets the time and the alarm, starts or stops the counter, enables interrupts and reads status. The status register shows a busy flag for the last tick period before every update, so software can pick a safe window for reading the time. It also shows single-tick event flags when a second, minute, hour or day completes, and a sticky alarm flag. The alarm flag is set when all six alarm fields equal the new time, and software clears it by writing a one to it. Two registered interrupt lines gate the seconds event and the alarm flag with their enables.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. Control, status, interrupt-enable and all alarm bytes read 0x00. Register byte offsets: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14; alarm fields at the same order from 0x20 to 0x34; control 0x40, status 0x44, interrupt enable 0x48. Any other offset reads 0x00. A read returns data on `rdata` one clock after `rd_en`.
- R2: With control bit 0 set, the time moves forward by one second on every TICKS_PER_SEC-th `tick`. With that bit clear, ticks are ignored and the time holds.
- R3: Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, month 12 wraps to 01 and increments the year, and year 99 wraps to 00. Each carry follows BCD digit order (for example, 09 becomes 10).
- R4: Day wraps to 01 after the last day of the current month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 29 for February in years divisible by four (otherwise 28).
- R5: A write to any time register takes effect at once and restarts the sub-second count, so the next increment comes a full TICKS_PER_SEC ticks later.
- R6: Status bit 6 (alarm) sets on the update whose new time equals all six alarm bytes. A difference in any single field, the year included, prevents it.
- R7: Writing a 1 to status bit 6 clears the alarm flag. Writing a 0 to it leaves the flag set.
- R8: Status bit 0 (busy) is 1 from the tick that precedes an update until that update, and 0 after it. Status bit 1 mirrors the run bit.
- R9: Status bits 2, 3, 4 and 5 flag the completion of a second, a minute, an hour and a day on the update that causes it. They return to 0 at the next tick.
- R10: `irq_timer` follows (status bit 2 AND enable bit 2), and `irq_alarm` follows (status bit 6 AND enable bit 3), both one clock later.
- R11: Only 24-hour counting exists: control bit 3 is ignored on write and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and tick logic |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sub-second enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_timer | output | 1 | Per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench targets the full carry chain from 99-12-31 23:59:59 to 00-01-01 00:00:00. A design that broke the chain partway through would leave one field unchanged. The bench also drives February in both leap and non-leap years and the 30-day months, where a wrong day limit would produce day 29, 30 or 32. It sets an alarm that differs only in the year, which catches a comparator that ignores a field. It checks that a write of zero leaves the alarm flag in place, and that a time write restarts the second, so a design that kept the old phase would count the next second too early. Finally, it reads the busy and event bits tick by tick around an update, so a busy window that opens or closes one tick off is exposed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELDS = 6;
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_MON = 4;
  localparam int F_YR  = 5;

  localparam logic [7:0] OFS_ALARM = 8'h20;
  localparam logic [7:0] OFS_CTRL  = 8'h40;
  localparam logic [7:0] OFS_STAT  = 8'h44;
  localparam logic [7:0] OFS_IE    = 8'h48;

  localparam int CTRL_RUN   = 0;
  localparam int ST_ALARM   = 6;
  localparam int IE_TIMER   = 2;
  localparam int IE_ALARM   = 3;

  // Lowest legal value of each field (day and month start at 1).
  function automatic logic [7:0] field_floor(input int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  // Last day of a month, all values in BCD.
  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                     return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] LOW = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] lim,
  output logic [7:0] val,
  output logic [7:0] nxt
);
  always_comb begin
    if (!inc)                  nxt = val;
    else if (val >= lim)       nxt = LOW;
    else if (val[3:0] >= 4'h9) nxt = {val[7:4] + 4'h1, 4'h0};
    else                       nxt = val + 8'h01;
  end

  always_ff @(posedge clk) begin
    if (rst)     val <= LOW;
    else if (ld) val <= ld_val;
    else         val <= nxt;
  end
endmodule

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic upd,
  output logic busy
);
  localparam int W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [W-1:0] LAST = W'(TICKS_PER_SEC - 1);

  logic [W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst || clr)       sub_q <= '0;
    else if (tick && run) sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
  end

  assign upd  = tick && run && (sub_q == LAST) && !clr;
  assign busy = run && (sub_q == LAST);
endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       upd,
  input  logic [3:0] unit_done,
  input  logic       match,
  input  logic       alm_clr,
  output logic [3:0] ev,
  output logic       alm_flag
);
  always_ff @(posedge clk) begin
    if (rst)              ev <= '0;
    else if (tick && run) ev <= upd ? unit_done : 4'h0;
  end

  always_ff @(posedge clk) begin
    if (rst)                alm_flag <= 1'b0;
    else if (upd && match)  alm_flag <= 1'b1;
    else if (alm_clr)       alm_flag <= 1'b0;
  end
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_timer,
  output logic          irq_alarm
);
  logic [NFIELDS-1:0][7:0] tv, nxt, lim, alarm_q;
  logic [NFIELDS-1:0]      inc, time_ld;
  logic [2:0]              fidx;
  logic                    word_ok, is_time, is_alarm, time_wr;
  logic                    run_q, ie_tmr, ie_alm;
  logic                    upd, busy, match, alm_clr, alm_flag;
  logic [3:0]              ev;
  logic [7:0]              rd_mux;

  // Address decode
  assign fidx     = addr[4:2];
  assign word_ok  = (addr[1:0] == 2'b00) && (fidx < 3'(NFIELDS));
  assign is_time  = word_ok && (addr[AW-1:5] == '0);
  assign is_alarm = word_ok && (addr[AW-1:5] == (AW-5)'(OFS_ALARM[7:5]));
  assign time_wr  = wr_en && is_time;
  assign alm_clr  = wr_en && (addr == AW'(OFS_STAT)) && wdata[ST_ALARM];

  // Field limits
  always_comb begin
    lim[F_SEC] = 8'h59;
    lim[F_MIN] = 8'h59;
    lim[F_HR]  = 8'h23;
    lim[F_DAY] = month_last_day(tv[F_MON], tv[F_YR]);
    lim[F_MON] = 8'h12;
    lim[F_YR]  = 8'h99;
  end

  rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
    .clk(clk), .rst(rst), .tick(tick), .run(run_q), .clr(time_wr),
    .upd(upd), .busy(busy)
  );

  assign inc[0] = upd;

  for (genvar i = 0; i < NFIELDS; i++) begin : g_field
    assign time_ld[i] = time_wr && (fidx == 3'(i));
    if (i > 0) begin : g_carry
      assign inc[i] = inc[i-1] && (tv[i-1] >= lim[i-1]);
    end
    rtc_bcd_field #(.LOW(field_floor(i))) u_fld (
      .clk(clk), .rst(rst), .inc(inc[i]), .ld(time_ld[i]),
      .ld_val(wdata), .lim(lim[i]), .val(tv[i]), .nxt(nxt[i])
    );
    always_ff @(posedge clk) begin
      if (rst)                                    alarm_q[i] <= 8'h00;
      else if (wr_en && is_alarm && fidx == 3'(i)) alarm_q[i] <= wdata;
    end
  end

  // Alarm compares the value the fields take at this update
  always_comb begin
    match = 1'b1;
    for (int k = 0; k < NFIELDS; k++)
      if (nxt[k] != alarm_q[k]) match = 1'b0;
  end

  rtc_event_unit u_events (
    .clk(clk), .rst(rst), .tick(tick), .run(run_q), .upd(upd),
    .unit_done(inc[3:0]), .match(match), .alm_clr(alm_clr),
    .ev(ev), .alm_flag(alm_flag)
  );

  // Control and interrupt enable
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ie_tmr <= 1'b0;
      ie_alm <= 1'b0;
    end else if (wr_en) begin
      if (addr == AW'(OFS_CTRL)) run_q <= wdata[CTRL_RUN];
      if (addr == AW'(OFS_IE)) begin
        ie_tmr <= wdata[IE_TIMER];
        ie_alm <= wdata[IE_ALARM];
      end
    end
  end

  // Read path
  always_comb begin
    rd_mux = 8'h00;
    if (is_time)                    rd_mux = tv[fidx];
    else if (is_alarm)              rd_mux = alarm_q[fidx];
    else if (addr == AW'(OFS_CTRL)) rd_mux = {7'b0, run_q};
    else if (addr == AW'(OFS_STAT)) rd_mux = {1'b0, alm_flag, ev, run_q, busy};
    else if (addr == AW'(OFS_IE))   rd_mux = {4'b0, ie_alm, ie_tmr, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= 8'h00;
      irq_timer <= 1'b0;
      irq_alarm <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq_timer <= ev[0] && ie_tmr;
      irq_alarm <= alm_flag && ie_alm;
    end
  end
endmodule

// File: rtl/bcd_calendar_rtc_chk.sv
module bcd_calendar_rtc_chk
  import rtc_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [NFIELDS-1:0][7:0] tv,
  input logic [NFIELDS-1:0][7:0] alarm_q,
  input logic [NFIELDS-1:0]      time_ld,
  input logic                    upd,
  input logic                    busy,
  input logic                    alm_flag,
  input logic                    alm_clr,
  input logic [3:0]              ev,
  input logic                    ie_tmr,
  input logic                    ie_alm,
  input logic                    irq_timer,
  input logic                    irq_alarm
);
  assert_sec_bcd_R2: assert property (@(posedge clk) disable iff (rst)
    tv[F_SEC][7:4] <= 4'h5 && tv[F_SEC][3:0] <= 4'h9);

  assert_sec_moves_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(tv[F_SEC]) |-> $past(upd || time_ld[F_SEC]));

  assert_hour_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (|time_ld) || tv[F_HR] <= 8'h23 || $past(|time_ld));

  assert_day_month_R4: assert property (@(posedge clk) disable iff (rst)
    $past(upd) |-> (tv[F_MON] != 8'h00 && tv[F_DAY] != 8'h00));

  assert_alarm_match_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(alm_flag) |-> tv == $past(alarm_q));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(alm_flag) |-> $past(alm_clr));

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
    upd |=> !busy);

  assert_irq_timer_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_timer) |-> $past(ev[0] && ie_tmr));

  assert_irq_alarm_R10: assert property (@(posedge clk) disable iff (rst)
    irq_alarm |-> $past(alm_flag && ie_alm));
endmodule

bind bcd_calendar_rtc bcd_calendar_rtc_chk u_chk (
  .clk(clk), .rst(rst), .tv(tv), .alarm_q(alarm_q), .time_ld(time_ld),
  .upd(upd), .busy(busy), .alm_flag(alm_flag), .alm_clr(alm_clr), .ev(ev),
  .ie_tmr(ie_tmr), .ie_alm(ie_alm), .irq_timer(irq_timer), .irq_alarm(irq_alarm)
);

// File: tb/bcd_calendar_rtc_tb.sv
`timescale 1ns/1ps
module bcd_calendar_rtc_tb;
  localparam int TPS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic irq_timer, irq_alarm;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS), .AW(8)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_timer(irq_timer), .irq_alarm(irq_alarm)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    bus_write(8'h14, y);  bus_write(8'h10, mo); bus_write(8'h0C, d);
    bus_write(8'h08, h);  bus_write(8'h04, mi); bus_write(8'h00, s);
  endtask

  task automatic chk_time(input string tag, input logic [7:0] y, mo, d, h, mi, s);
    rd_chk(tag, 8'h14, y);  rd_chk(tag, 8'h10, mo); rd_chk(tag, 8'h0C, d);
    rd_chk(tag, 8'h08, h);  rd_chk(tag, 8'h04, mi); rd_chk(tag, 8'h00, s);
  endtask

  task automatic t_reset;
    chk_time("R1 reset time", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd_chk("R1 ctrl", 8'h40, 8'h00);
    rd_chk("R1 status", 8'h44, 8'h00);
    rd_chk("R1 ie", 8'h48, 8'h00);
    rd_chk("R1 alarm sec", 8'h20, 8'h00);
    rd_chk("R1 alarm year", 8'h34, 8'h00);
    rd_chk("R1 unmapped", 8'h3C, 8'h00);
  endtask

  task automatic t_stopped;
    tick_n(3 * TPS);
    rd_chk("R2 stopped sec", 8'h00, 8'h00);
    rd_chk("R8 stopped status", 8'h44, 8'h00);
  endtask

  task automatic t_count_busy;
    bus_write(8'h40, 8'h01);
    rd_chk("R8 run bit", 8'h44, 8'h02);
    tick_n(TPS - 1);
    rd_chk("R8 busy before update", 8'h44, 8'h03);
    tick_n(1);
    rd_chk("R2 first second", 8'h00, 8'h01);
    rd_chk("R9 sec event", 8'h44, 8'h06);
    tick_n(1);
    rd_chk("R9 event clears", 8'h44, 8'h02);
    tick_n(TPS - 1);
    rd_chk("R2 second second", 8'h00, 8'h02);
  endtask

  task automatic t_subsec;
    tick_n(3);
    bus_write(8'h00, 8'h30);
    rd_chk("R5 immediate", 8'h00, 8'h30);
    tick_n(TPS - 1);
    rd_chk("R5 no early step", 8'h00, 8'h30);
    tick_n(1);
    rd_chk("R5 full second", 8'h00, 8'h31);
  endtask

  task automatic t_rollover;
    bus_write(8'h40, 8'h09);
    rd_chk("R11 mode bit ignored", 8'h40, 8'h01);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    tick_n(TPS);
    rd_chk("R9 all events", 8'h44, 8'h3E);
    chk_time("R3 full wrap", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h05, 8'h03, 8'h10, 8'h09, 8'h59, 8'h59);
    tick_n(TPS);
    chk_time("R3 digit carry", 8'h05, 8'h03, 8'h10, 8'h10, 8'h00, 8'h00);
  endtask

  task automatic roll_day(input string tag, input logic [7:0] y, mo, d,
                          input logic [7:0] emo, ed);
    set_time(y, mo, d, 8'h23, 8'h59, 8'h59);
    tick_n(TPS);
    rd_chk(tag, 8'h10, emo);
    rd_chk(tag, 8'h0C, ed);
  endtask

  task automatic t_month_len;
    roll_day("R4 leap feb 28", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    roll_day("R4 leap feb 29", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    roll_day("R4 plain feb 28", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    roll_day("R4 april 30", 8'h23, 8'h04, 8'h30, 8'h05, 8'h01);
    roll_day("R4 jan 30", 8'h23, 8'h01, 8'h30, 8'h01, 8'h31);
    roll_day("R4 nov 30", 8'h23, 8'h11, 8'h30, 8'h12, 8'h01);
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    bus_write(8'h48, 8'h08);
    set_time(8'h05, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    bus_write(8'h34, 8'h06); bus_write(8'h30, 8'h06); bus_write(8'h2C, 8'h15);
    bus_write(8'h28, 8'h10); bus_write(8'h24, 8'h20); bus_write(8'h20, 8'h31);
    tick_n(TPS);
    rd_chk("R6 year mismatch no alarm", 8'h44, 8'h06);
    chk("R10 no alarm irq", {7'b0, irq_alarm}, 8'h00);
    bus_write(8'h34, 8'h05); bus_write(8'h20, 8'h32);
    tick_n(TPS);
    rd_chk("R6 alarm set", 8'h44, 8'h46);
    chk("R10 alarm irq", {7'b0, irq_alarm}, 8'h01);
    bus_write(8'h48, 8'h00);
    @(negedge clk);
    chk("R10 alarm irq masked", {7'b0, irq_alarm}, 8'h00);
    bus_write(8'h48, 8'h08);
    bus_write(8'h44, 8'hBF);
    bus_read(8'h44, v);
    chk("R7 write zero keeps flag", v & 8'h40, 8'h40);
    bus_write(8'h44, 8'h40);
    bus_read(8'h44, v);
    chk("R7 write one clears", v & 8'h40, 8'h00);
    chk("R10 alarm irq drops", {7'b0, irq_alarm}, 8'h00);
  endtask

  task automatic t_irq_timer;
    bus_write(8'h48, 8'h04);
    tick_n(TPS);
    @(negedge clk);
    chk("R10 timer irq", {7'b0, irq_timer}, 8'h01);
    tick_n(1);
    @(negedge clk);
    chk("R10 timer irq pulse ends", {7'b0, irq_timer}, 8'h00);
    bus_write(8'h48, 8'h00);
    tick_n(TPS - 1);
    @(negedge clk);
    rd_chk("R9 event with irq off", 8'h44, 8'h06);
    chk("R10 timer irq disabled", {7'b0, irq_timer}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stopped();
    t_count_busy();
    t_subsec();
    t_rollover();
    t_month_len();
    t_alarm();
    t_irq_timer();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule